// File: doc/BRIEF.md
# Adaptive Voltage Bus Serial Frame Master

This block is the serial master end of an adaptive-voltage bus link to a single voltage-regulator slave. The host places a command on the input fields and pulses `start`. The command fields are the command type, command group, data type, rail select and a 16-bit data word. The master builds a 32-bit frame and shifts it out on `mosi` under its own serial clock while `cs_n` is low. At the same time it captures the slave's 32-bit reply on `miso`. While the frame goes out, it computes a 3-bit CRC one bit at a time and appends it. When the frame ends it presents the voltage field of the reply on `rdata`, pulses `done`, and records a CRC mismatch in the reply on a sticky `crc_err` flag.

The controller has three named states. `ST_IDLE` waits for an accepted start (transition *launch*, to `ST_LOW`). `ST_LOW` holds the serial clock low until the divider tick (transition *rise*, to `ST_HIGH`), which drives the next bit. `ST_HIGH` holds it high until the next tick. That tick is the *fall*: it samples `miso` and returns to `ST_LOW`, or, for bit 32, the *finish* transition returns to `ST_IDLE`.

An all-ones idle frame can be requested with `cmd_idle`. The slave must receive one before it accepts voltage writes, so the master refuses write commands until an idle frame has completed. The host sets the serial rate with `cfg_div` = f_core / (8 × f_bus) − 1. For a 10 MHz bus this works out to f_core / 80 MHz − 1.

Top module: `avs_master`

## Requirements
- R1: After reset, `busy`, `done`, `sclk` and `crc_err` are 0, `cs_n` and `mosi` are 1, and `rdata` is 0.
- R2: A command frame is sent most significant bit first. Its bits are: [31:30] = 2'b01 start code, [29:28] = command type, [27] = group, [26:23] = data type, [22:19] = rail select, [18:3] = data, [2:0] = CRC.
- R3: The CRC field is computed over frame bits 31..3 in sending order. It uses a 3-bit register cleared to 0: for each bit b, x = b ^ c[2] and c becomes {c[1], c[0]^x, x}. Bit c[2] is sent first.
- R4: When the command type is 2'b11 (read), the data field is sent as 16'hFFFF whatever `cmd_data` holds.
- R5: With `cmd_idle` = 1, the frame is 32 ones, CRC field included.
- R6: A write command (command type 2'b00 or 2'b01) that starts before any idle frame has completed since reset is ignored: `cs_n` stays 1 and `busy` stays 0.
- R7: The start edge drives `cs_n` low. Each serial half-period lasts 4 × (`cfg_div`+1) core cycles, and `sclk` starts low (clock polarity 0). `mosi` changes only on the rising edge of `sclk`, and `miso` is sampled on the falling edge (clock phase 1). `mosi` rests at 1 outside a frame.
- R8: `busy` is 1 from the start edge until the edge that samples bit 32. That same edge raises `done` for one cycle and drives `cs_n` back high. A `start` pulse while `busy` is 1 has no effect.
- R9: `cfg_div` is captured on the start edge, so changing it during a frame leaves that frame's timing unchanged.
- R10: On `done`, `rdata` takes bits [23:8] of the received frame and holds them until the next `done`.
- R11: On `done` of a non-idle frame, `crc_err` is set if the received bits [2:0] differ from the R3 CRC of received bits 31..3. The flag stays set until `crc_clr` clears it in the next cycle, and a setting event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch strobe for one frame |
| cmd_idle | input | 1 | Send an all-ones idle frame instead of a command |
| cmd_type | input | 2 | Command type (2'b11 = read, 2'b00/2'b01 = write) |
| cmd_group | input | 1 | Command group |
| cmd_dtype | input | 4 | Data type |
| cmd_rail | input | 4 | Rail select |
| cmd_data | input | 16 | Write data |
| cfg_div | input | 10 | Serial clock divider |
| crc_clr | input | 1 | Clears `crc_err` |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rdata | output | 16 | Voltage field of the last reply |
| crc_err | output | 1 | Sticky reply CRC mismatch |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slave |
| cs_n | output | 1 | Active-low frame select |
| miso | input | 1 | Serial data from slave |

## Verification
The frame engine is tried with five patterns. A write attempted before initialization separates gated from ungated writes. A read with non-FFFF host data shows whether the data field is forced. An idle frame shows whether the CRC is overridden. A plain write exercises the header layout and the computed CRC. A slow-divider frame is hit mid-flight with a fresh start and a new divider value, which separates latched timing from live timing. Replies are sent both with a correct and with a corrupted CRC, which tells whether `crc_err` responds to the CRC value rather than to the frame count. The bench compares every serial line, `busy`, `done`, `rdata` and `crc_err` against a cycle-indexed model on every clock.

// File: rtl/avs_pkg.sv
package avs_pkg;
    localparam int FRAME_W  = 32;
    localparam int CRC_W    = 3;
    localparam int DATA_W   = 16;
    localparam logic [1:0] START_CODE = 2'b01;
    localparam logic [1:0] CMD_READ   = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH
    } state_e;
endpackage

// File: rtl/avs_crc3.sv
module avs_crc3
    import avs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             din,
    output logic [CRC_W-1:0] crc
);
    logic fb;
    assign fb = din ^ crc[CRC_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            crc <= '0;
        else if (clr)
            crc <= '0;
        else if (en)
            crc <= {crc[1], crc[0] ^ fb, fb};
    end
endmodule

// File: rtl/avs_clk_div.sv
module avs_clk_div #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] lim,
    output logic             tick
);
    logic [CNT_W-1:0] cnt_q;

    assign tick = run && (cnt_q == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/avs_master.sv
module avs_master
    import avs_pkg::*;
#(
    parameter int DIV_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cmd_idle,
    input  logic [1:0]        cmd_type,
    input  logic              cmd_group,
    input  logic [3:0]        cmd_dtype,
    input  logic [3:0]        cmd_rail,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              crc_clr,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              crc_err,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n,
    input  logic              miso
);
    localparam int CNT_W     = DIV_W + 2;
    localparam int IDX_W     = $clog2(FRAME_W);
    localparam int CRC_FIRST = FRAME_W - CRC_W;
    localparam int RD_MSB    = FRAME_W - 9;

    state_e              state_q, state_d;
    logic [DIV_W-1:0]    div_q;
    logic                tick, accept, last_bit, crc_phase, is_write, crc_bit;
    logic [IDX_W-1:0]    idx_q;
    logic [FRAME_W-1:0]  tx_q, rx_q, rx_nx, frame_w;
    logic                idle_q, ready_q;
    logic [CRC_W-1:0]    tx_crc, rx_crc;
    logic                rise, fall;

    assign is_write  = (cmd_type[1] == 1'b0);
    assign accept    = (state_q == ST_IDLE) && start && (cmd_idle || !is_write || ready_q);
    assign crc_phase = (idx_q >= IDX_W'(CRC_FIRST));
    assign last_bit  = (idx_q == IDX_W'(FRAME_W - 1));
    assign rx_nx     = {rx_q[FRAME_W-2:0], miso};
    assign rise      = (state_q == ST_LOW)  && tick;
    assign fall      = (state_q == ST_HIGH) && tick;

    always_comb begin
        if (cmd_idle)
            frame_w = '1;
        else
            frame_w = {START_CODE, cmd_type, cmd_group, cmd_dtype, cmd_rail,
                       (cmd_type == CMD_READ) ? {DATA_W{1'b1}} : cmd_data,
                       {CRC_W{1'b0}}};
    end

    always_comb begin
        unique case (idx_q[1:0])
            2'b01:   crc_bit = tx_crc[2];
            2'b10:   crc_bit = tx_crc[1];
            default: crc_bit = tx_crc[0];
        endcase
    end

    avs_clk_div #(.CNT_W(CNT_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q != ST_IDLE),
        .lim   ({div_q, 2'b11}),
        .tick  (tick)
    );

    avs_crc3 u_tx_crc (
        .clk (clk), .rst_n (rst_n), .clr (accept),
        .en  (rise && !crc_phase), .din (tx_q[FRAME_W-1]), .crc (tx_crc)
    );

    avs_crc3 u_rx_crc (
        .clk (clk), .rst_n (rst_n), .clr (accept),
        .en  (fall && !crc_phase), .din (miso), .crc (rx_crc)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_LOW;
            ST_LOW:  if (tick)   state_d = ST_HIGH;
            ST_HIGH: if (tick)   state_d = last_bit ? ST_IDLE : ST_LOW;
            default:             state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            rdata   <= '0;
            crc_err <= 1'b0;
            sclk    <= 1'b0;
            mosi    <= 1'b1;
            cs_n    <= 1'b1;
            div_q   <= '0;
            idx_q   <= '0;
            tx_q    <= '0;
            rx_q    <= '0;
            idle_q  <= 1'b0;
            ready_q <= 1'b0;
        end else begin
            done <= 1'b0;
            if (crc_clr)
                crc_err <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        cs_n   <= 1'b0;
                        busy   <= 1'b1;
                        tx_q   <= frame_w;
                        idle_q <= cmd_idle;
                        div_q  <= cfg_div;
                        idx_q  <= '0;
                    end
                end
                ST_LOW: begin
                    if (tick) begin
                        sclk <= 1'b1;
                        mosi <= (idle_q || !crc_phase) ? tx_q[FRAME_W-1] : crc_bit;
                        tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
                    end
                end
                ST_HIGH: begin
                    if (tick) begin
                        sclk  <= 1'b0;
                        rx_q  <= rx_nx;
                        idx_q <= idx_q + 1'b1;
                        if (last_bit) begin
                            cs_n  <= 1'b1;
                            busy  <= 1'b0;
                            done  <= 1'b1;
                            mosi  <= 1'b1;
                            rdata <= rx_nx[RD_MSB -: DATA_W];
                            if (!idle_q && (rx_crc != rx_nx[CRC_W-1:0]))
                                crc_err <= 1'b1;
                            if (idle_q)
                                ready_q <= 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/avs_master_chk.sv
module avs_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic [15:0] rdata,
    input logic        crc_err,
    input logic        sclk,
    input logic        mosi,
    input logic        cs_n
);
    // R7
    sclk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);

    // R7
    mosi_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n) && !$rose(sclk)) |-> $stable(mosi));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($fell(busy) && cs_n));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rdata));

    // R11
    err_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_err) |-> done);
endmodule

bind avs_master avs_master_chk u_chk (.*);

// File: tb/avs_master_bench.sv
`timescale 1ns/1ps
module avs_master_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 0, cmd_idle = 0, cmd_group = 0, crc_clr = 0, miso = 1;
    logic [1:0] cmd_type = 0;
    logic [3:0] cmd_dtype = 0, cmd_rail = 0;
    logic [15:0] cmd_data = 0;
    logic [9:0] cfg_div = 0;
    logic busy, done, crc_err, sclk, mosi, cs_n;
    logic [15:0] rdata;

    int tests = 0, fails = 0;
    bit finished = 0;
    logic [15:0] exp_rdata = 0;
    logic exp_err = 0;

    always #2.5 clk = ~clk;

    avs_master u_avs_master (.*);

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            if (fails < 40)
                $display("FAIL %s %s: actual %h expected %h @%0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] crc_of(logic [31:0] f);
        logic [2:0] c = 3'b000;
        for (int i = 31; i >= 3; i--) begin
            logic x;
            x = f[i] ^ c[2];
            c = {c[1], c[0] ^ x, x};
        end
        return c;
    endfunction

    function automatic logic [31:0] build(bit idl, logic [1:0] ty, logic g,
                                          logic [3:0] dt, logic [3:0] rl, logic [15:0] d);
        logic [31:0] f;
        if (idl) return 32'hFFFF_FFFF;
        f = {2'b01, ty, g, dt, rl, (ty == 2'b11) ? 16'hFFFF : d, 3'b000};
        f[2:0] = crc_of(f);
        return f;
    endfunction

    task automatic run_frame(bit idl, logic [1:0] ty, logic g, logic [3:0] dt,
                             logic [3:0] rl, logic [15:0] d, logic [9:0] dv,
                             logic [31:0] resp, int inj, string ttag, string mtag);
        logic [31:0] fb;
        int h, last;
        fb = build(idl, ty, g, dt, rl, d);
        h = 4 * (int'(dv) + 1);
        last = 64 * h;
        @(negedge clk);
        cmd_idle = idl; cmd_type = ty; cmd_group = g; cmd_dtype = dt;
        cmd_rail = rl; cmd_data = d; cfg_div = dv; start = 1;
        for (int m = 0; m <= last + 6; m++) begin
            int r;
            logic e_sclk, e_mosi;
            @(negedge clk);
            if (m == 0) start = 0;
            if (m == last) begin
                exp_rdata = resp[23:8];
                if (!idl && (crc_of(resp) != resp[2:0])) exp_err = 1;
            end
            r = (m / h + 1) / 2;
            e_sclk = (m < last) && ((m / h) % 2 == 1);
            e_mosi = (m >= last || r == 0) ? 1'b1 : fb[32 - r];
            chk(ttag, "sclk", sclk, e_sclk);
            chk(ttag, "cs_n", cs_n, (m < last) ? 1'b0 : 1'b1);
            chk(mtag, "mosi", mosi, e_mosi);
            chk("R8", "busy", busy, (m < last) ? 1'b1 : 1'b0);
            chk("R8", "done", done, (m == last) ? 1'b1 : 1'b0);
            chk("R10", "rdata", rdata, exp_rdata);
            chk("R11", "crc_err", crc_err, exp_err);
            if (m < last && m % h == 0 && (m / h) % 2 == 1)
                miso = resp[31 - (m / h - 1) / 2];
            if (m >= last) miso = 1;
            if (inj > 0 && m == inj) begin
                start = 1; cmd_idle = 0; cmd_type = 2'b00; cmd_data = 16'h1234;
                cfg_div = dv + 10'd3;
            end
            if (inj > 0 && m == inj + 1) start = 0;
        end
        cfg_div = dv;
    endtask

    function automatic logic [31:0] reply(logic [28:0] body, bit good);
        logic [31:0] f;
        f = {body, 3'b000};
        f[2:0] = good ? crc_of(f) : ~crc_of(f);
        return f;
    endfunction

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "busy", busy, 0);   chk("R1", "done", done, 0);
        chk("R1", "sclk", sclk, 0);   chk("R1", "cs_n", cs_n, 1);
        chk("R1", "mosi", mosi, 1);   chk("R1", "rdata", rdata, 0);
        chk("R1", "crc_err", crc_err, 0);

        // R6 write before any idle frame is ignored
        cmd_idle = 0; cmd_type = 2'b00; cmd_data = 16'h0384; start = 1;
        @(negedge clk); start = 0;
        for (int i = 0; i < 12; i++) begin
            chk("R6", "cs_n", cs_n, 1);
            chk("R6", "busy", busy, 0);
            @(negedge clk);
        end

        // R4 read forces FFFF data; R10 reply field; good reply CRC
        run_frame(0, 2'b11, 1'b0, 4'h0, 4'h5, 16'h1357, 10'd0,
                  reply(29'h0ABC_DEF1, 1), 0, "R7", "R4");
        // R5 idle frame, also unlocks writes
        run_frame(1, 2'b00, 1'b0, 4'h0, 4'h0, 16'h0000, 10'd0,
                  32'h0000_0005, 0, "R7", "R5");
        // R2 R3 write frame layout and CRC
        run_frame(0, 2'b00, 1'b1, 4'h0, 4'h2, 16'h03E8, 10'd1,
                  reply(29'h1234_5678, 1), 0, "R7", "R2 R3");
        // R8 R9 start and divider change mid-frame ignored
        run_frame(0, 2'b01, 1'b0, 4'hA, 4'h9, 16'hC0DE, 10'd2,
                  reply(29'h0F0F_0F0F, 1), 100, "R9", "R2 R3");
        // R11 bad reply CRC sets the sticky flag
        run_frame(0, 2'b11, 1'b0, 4'h0, 4'h1, 16'h0000, 10'd0,
                  reply(29'h1555_AAAA, 0), 0, "R7", "R4");
        repeat (3) begin
            @(negedge clk);
            chk("R11", "crc_err sticky", crc_err, 1);
        end
        crc_clr = 1;
        @(negedge clk); crc_clr = 0; exp_err = 0;
        chk("R11", "crc_err cleared", crc_err, 0);
        // R11 good reply leaves flag clear
        run_frame(0, 2'b00, 1'b0, 4'h3, 4'h7, 16'hBEEF, 10'd0,
                  reply(29'h0000_1111, 1), 0, "R7", "R2 R3");

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule